// File: doc/BRIEF.md
# E3 Transmit Frame Aligner

This block assembles the serial transmit frame of an E3 line. A frame is 1536 bit periods long and opens with a contiguous 12-bit overhead field. A position counter tracks which bit of the frame is being accepted on the serial input. The counter can run freely as the frame generator, or it can follow a rising edge on an external sync input. Three outputs are produced:

- a frame marker that travels with the output stream;
- a data request strobe that skips the overhead interval;
- the NRZ serial stream, with the overhead field written in.

Upstream logic may feed the block in one of two ways. In slotted feeding, the input stream already reserves the twelve overhead positions. The block overwrites those positions with its own overhead, unless pass-through of externally built overhead is selected. In gapped feeding, the upstream source needs no frame timing. It presents a new bit only when the request strobe tells it to. The request strobe lags the overhead window by one cycle, so the bit presented last before the overhead stays on the input through the overhead interval. That bit is consumed as the first information bit after the overhead.

The whole block runs on one clock. Its active edge stands for the edge on which the line-side transmit clock samples data.

Top module: `e3_tx_framer`

## Requirements
- R1: The frame is 1536 positions long and the position counter wraps from 1536 to 1. `fs_out` is high for exactly one cycle per frame: the cycle in which `nrz_out` carries frame position 1.
- R2: In positions 1 to 10 the internal overhead sends the alignment word 1111010000, leftmost bit at position 1. Position 11 carries `rai_in` and position 12 carries `nat_in`.
- R3: In slotted mode (`gap_mode`=0) with `ext_oh_en`=0, the input values in positions 1 to 12 have no effect on `nrz_out`. The internal overhead of R2 appears there instead.
- R4: In slotted mode with `ext_oh_en`=1, all 1536 positions, overhead included, carry the input bit unchanged.
- R5: A bit sampled on `ser_in` at a clock edge appears on `nrz_out` right after the second following edge (two cycles of latency).
- R6: With `ext_sync_en`=1, a sample of `sync_in`=1 that follows a sample of 0 makes the bit sampled at that edge frame position 1. This re-aligns the counter from any position.
- R7: With `ext_sync_en`=0, the counter runs freely and `sync_in` has no effect on frame timing.
- R8: `gap_en` is high in a cycle exactly when the previous edge sampled a position in 13 to 1536. It is therefore low in the cycles whose current position is 2 to 13.
- R9: In gapped mode (`gap_mode`=1) the source presents a new bit in each cycle in which `gap_en` is high. The information positions carry the source bits in order, with none lost or repeated. The bit presented at position 1 is held and sent at position 13.
- R10: In gapped mode `ext_oh_en` has no effect: positions 1 to 12 always carry the internal overhead.
- R11: After reset the counter is at position 1, and `nrz_out`, `fs_out` and `gap_en` are 0. `gap_en` first rises only after the first overhead field has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock; the rising edge is the active edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data input, one bit per cycle |
| sync_in | input | 1 | External frame sync; a rising edge marks the frame boundary |
| ext_sync_en | input | 1 | 1: follow `sync_in`; 0: free-running counter |
| gap_mode | input | 1 | 0: slotted input; 1: gapped input driven by `gap_en` |
| ext_oh_en | input | 1 | In slotted mode, pass the input overhead bits through |
| rai_in | input | 1 | Value sent in overhead position 11 |
| nat_in | input | 1 | Value sent in overhead position 12 |
| gap_en | output | 1 | Data request strobe that skips the overhead interval |
| fs_out | output | 1 | Frame marker, aligned to position 1 on `nrz_out` |
| nrz_out | output | 1 | Serial NRZ frame output |

## Verification
A position counter that is off by even one place moves `fs_out` and the alignment word away from the bench's frame model. This shows within two cycles of the next frame boundary. A request strobe that fires one cycle early or late causes a skipped or repeated source bit in gapped mode. That slip then persists, so every later information bit on `nrz_out` mismatches and the fault appears at the first information bit after the overhead. A wrong overhead-select decision shows as a wrong bit in the twelve positions after `fs_out`. The bench therefore fills the overhead slots with the complement of the expected overhead.

// File: rtl/e3f_pkg.sv
// e3f_pkg: constants and helpers shared by the E3 transmit frame aligner.
// Assumes the overhead field is the alignment word followed by two
// single-bit fields (remote alarm, national use).
package e3f_pkg;

    localparam int FAS_LEN   = 10;
    localparam int OH_LEN    = FAS_LEN + 2;
    localparam int FAS_IDX_W = $clog2(FAS_LEN);
    localparam logic [FAS_LEN-1:0] FAS_WORD = 10'b1111010000;

    // Overhead bit for 1-based frame position idx; outside 1..OH_LEN returns nat.
    function automatic logic oh_bit(input int idx, input logic rai, input logic nat);
        logic r;
        if (idx >= 1 && idx <= FAS_LEN) begin
            r = FAS_WORD[FAS_IDX_W'(FAS_LEN - idx)];
        end else if (idx == FAS_LEN + 1) begin
            r = rai;
        end else begin
            r = nat;
        end
        return r;
    endfunction

endpackage

// File: rtl/e3f_bit_counter.sv
// e3f_bit_counter: keeps the frame position (1..FRAME_LEN) of the bit that
// is sampled at the coming edge. When external sync is enabled, a rising
// edge on sync_in (sampled 1 after sampled 0) forces the current sample to
// position 1. Assumes synchronous active-low reset; sync_q resets high so a
// level that is already high at reset release is not taken as an edge.
module e3f_bit_counter #(
    parameter int FRAME_LEN = 1536,
    parameter int POS_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             ext_sync_en,
    output logic [POS_W-1:0] pos_eff,
    output logic [POS_W-1:0] cnt_q,
    output logic             sync_q
);

    localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN);

    logic sync_rise;

    // Detect a frame boundary marked by the external sync input.
    always_comb begin
        sync_rise = rst_n && ext_sync_en && sync_in && !sync_q;
    end

    // Position of the bit sampled at this edge.
    always_comb begin
        pos_eff = sync_rise ? ONE_POS : cnt_q;
    end

    // Advance the position counter and remember the last sync sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= ONE_POS;
            sync_q <= 1'b1;
        end else begin
            sync_q <= sync_in;
            cnt_q  <= (pos_eff == LAST_POS) ? ONE_POS : pos_eff + ONE_POS;
        end
    end

endmodule

// File: rtl/e3f_gap_gen.sv
// e3f_gap_gen: drives the data request strobe. The strobe is high in the
// cycle after an information position was sampled, so it lags the overhead
// window by one cycle. Assumes reset holds it low.
module e3f_gap_gen #(
    parameter int POS_W  = 11,
    parameter int OH_LEN = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_eff,
    output logic             gap_en
);

    localparam logic [POS_W-1:0] OH_POS = POS_W'(OH_LEN);

    // Request a new bit once an information position has been consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_en <= 1'b0;
        end else begin
            gap_en <= (pos_eff > OH_POS);
        end
    end

endmodule

// File: rtl/e3f_oh_mux.sv
// e3f_oh_mux: two-register output path. Stage 1 captures the input bit and
// its frame position. Stage 2 selects the input bit or the internal overhead
// and raises the frame marker alongside position 1. Assumes positions run
// from 1; a stage-1 position of 0 marks the empty pipeline after reset.
module e3f_oh_mux
    import e3f_pkg::*;
#(
    parameter int POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic [POS_W-1:0] pos_eff,
    input  logic             gap_mode,
    input  logic             ext_oh_en,
    input  logic             rai_in,
    input  logic             nat_in,
    output logic             nrz_out,
    output logic             fs_out
);

    localparam logic [POS_W-1:0] OH_POS  = POS_W'(OH_LEN);
    localparam logic [POS_W-1:0] ONE_POS = POS_W'(1);

    logic             s1_bit;
    logic [POS_W-1:0] s1_pos;
    logic             s1_in_oh;
    logic             take_int;
    logic             oh_val;

    // Stage 1: capture the sampled bit and its position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_bit <= 1'b0;
            s1_pos <= '0;
        end else begin
            s1_bit <= ser_in;
            s1_pos <= pos_eff;
        end
    end

    // Decide whether internal overhead replaces the captured bit.
    always_comb begin
        s1_in_oh = (s1_pos != '0) && (s1_pos <= OH_POS);
        take_int = s1_in_oh && (gap_mode || !ext_oh_en);
        oh_val   = oh_bit(int'(s1_pos), rai_in, nat_in);
    end

    // Stage 2: drive the serial output and the frame marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrz_out <= 1'b0;
            fs_out  <= 1'b0;
        end else begin
            nrz_out <= take_int ? oh_val : s1_bit;
            fs_out  <= (s1_pos == ONE_POS);
        end
    end

endmodule

// File: rtl/e3_tx_framer.sv
// e3_tx_framer: E3 transmit frame aligner top. It ties together the
// position counter, the request strobe generator and the output path.
// Assumes one clock domain whose rising edge is the line sampling edge,
// and a synchronous active-low reset.
module e3_tx_framer
    import e3f_pkg::*;
#(
    parameter int FRAME_LEN = 1536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    input  logic sync_in,
    input  logic ext_sync_en,
    input  logic gap_mode,
    input  logic ext_oh_en,
    input  logic rai_in,
    input  logic nat_in,
    output logic gap_en,
    output logic fs_out,
    output logic nrz_out
);

    localparam int POS_W = $clog2(FRAME_LEN + 1);

    logic [POS_W-1:0] pos_eff;
    logic [POS_W-1:0] cnt_q;
    logic             sync_q;

    e3f_bit_counter #(
        .FRAME_LEN(FRAME_LEN),
        .POS_W    (POS_W)
    ) counter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .ext_sync_en(ext_sync_en),
        .pos_eff    (pos_eff),
        .cnt_q      (cnt_q),
        .sync_q     (sync_q)
    );

    e3f_gap_gen #(
        .POS_W (POS_W),
        .OH_LEN(OH_LEN)
    ) gapgen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pos_eff(pos_eff),
        .gap_en (gap_en)
    );

    e3f_oh_mux #(
        .POS_W(POS_W)
    ) outpath_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .pos_eff  (pos_eff),
        .gap_mode (gap_mode),
        .ext_oh_en(ext_oh_en),
        .rai_in   (rai_in),
        .nat_in   (nat_in),
        .nrz_out  (nrz_out),
        .fs_out   (fs_out)
    );

endmodule

// File: rtl/e3_tx_framer_chk.sv
// e3_tx_framer_chk: temporal checks on the frame aligner, bound into the top.
// Assumes FRAME_LEN is larger than OH_LEN + 2.
module e3_tx_framer_chk #(
    parameter int FRAME_LEN = 1536,
    parameter int POS_W     = 11,
    parameter int OH_LEN    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_in,
    input logic             sync_in,
    input logic             ext_sync_en,
    input logic             gap_mode,
    input logic             ext_oh_en,
    input logic             gap_en,
    input logic             fs_out,
    input logic             nrz_out,
    input logic [POS_W-1:0] cnt_q,
    input logic [POS_W-1:0] pos_eff,
    input logic             sync_q
);

    localparam logic [POS_W-1:0] OH_POS   = POS_W'(OH_LEN);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN);
    localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);
    localparam logic [POS_W-1:0] TWO_POS  = POS_W'(2);

    // R1
    wrap_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_eff == LAST_POS) |=> (cnt_q == ONE_POS));

    // R1
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |=> !fs_out);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pos_eff, 2) > OH_POS) |-> (nrz_out == $past(ser_in, 2)));

    // R8
    gap_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gap_en) |-> (cnt_q == TWO_POS));

    // R8
    gap_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |-> !gap_en);

    // R6
    sync_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sync_en && sync_in && !sync_q) |=> (cnt_q == TWO_POS));

    // R7
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sync_en && cnt_q != LAST_POS) |=> (cnt_q == $past(cnt_q) + ONE_POS));

    // R2
    fas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_out && ($past(gap_mode) || !$past(ext_oh_en))) |-> nrz_out);

endmodule

bind e3_tx_framer e3_tx_framer_chk #(
    .FRAME_LEN(FRAME_LEN),
    .POS_W    (POS_W),
    .OH_LEN   (OH_LEN)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_in     (ser_in),
    .sync_in    (sync_in),
    .ext_sync_en(ext_sync_en),
    .gap_mode   (gap_mode),
    .ext_oh_en  (ext_oh_en),
    .gap_en     (gap_en),
    .fs_out     (fs_out),
    .nrz_out    (nrz_out),
    .cnt_q      (cnt_q),
    .pos_eff    (pos_eff),
    .sync_q     (sync_q)
);

// File: tb/e3_tx_framer_tb_top.sv
// Scoreboard bench: the driver task computes the expected output of every
// sampled bit from its own frame model and queues it; the monitor pops the
// items when they fall due and compares them with the ports.
module e3_tx_framer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 1536;
    localparam int OHL        = 12;
    localparam logic [9:0] ALIGN_WORD = 10'b1111010000;

    logic clk;
    logic rst_n;
    logic ser_in;
    logic sync_in;
    logic ext_sync_en;
    logic gap_mode;
    logic ext_oh_en;
    logic rai_in;
    logic nat_in;
    logic gap_en;
    logic fs_out;
    logic nrz_out;

    e3_tx_framer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .sync_in    (sync_in),
        .ext_sync_en(ext_sync_en),
        .gap_mode   (gap_mode),
        .ext_oh_en  (ext_oh_en),
        .rai_in     (rai_in),
        .nat_in     (nat_in),
        .gap_en     (gap_en),
        .fs_out     (fs_out),
        .nrz_out    (nrz_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int    due;
        bit    nrz;
        bit    fs;
        string tag;
    } out_exp_t;

    typedef struct {
        int due;
        bit g;
    } gap_exp_t;

    out_exp_t oq[$];
    gap_exp_t gq[$];

    int    cyc = 0;
    int    n_checks = 0;
    int    n_errors = 0;
    int    bpos;
    bit    last_sync;
    int    src_idx;
    int    info_cnt;
    string ovh_tag;
    string dat_tag;

    function automatic bit pat(input int j);
        logic [31:0] h;
        h = 32'(j) * 32'h9E3779B1;
        return h[17] ^ h[6];
    endfunction

    function automatic bit ref_oh(input int p);
        if (p <= 10) return ALIGN_WORD[10 - p];
        else if (p == 11) return rai_in;
        else return nat_in;
    endfunction

    task automatic chk(input string tag, input string what, input logic got, input bit exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s at cycle %0d: got %0b expected %0b", tag, what, cyc, got, exp);
        end
    endtask

    // Monitor: compare outputs shortly after each rising edge.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        while (oq.size() > 0 && oq[0].due <= cyc) begin
            out_exp_t e;
            e = oq.pop_front();
            if (e.due == cyc) begin
                chk(e.tag, "nrz_out", nrz_out, e.nrz);
                chk("R1", "fs_out", fs_out, e.fs);
            end
        end
        while (gq.size() > 0 && gq[0].due <= cyc) begin
            gap_exp_t g;
            g = gq.pop_front();
            if (g.due == cyc) chk("R8", "gap_en", gap_en, g.g);
        end
    end

    // Driver: present one bit at a falling edge and queue its expected result.
    task automatic drive_cycle(input bit sync_v);
        int    p;
        bit    d;
        bit    e;
        string tg;
        p = bpos;
        if (ext_sync_en && sync_v && !last_sync) p = 1;   // R6 boundary
        last_sync = sync_v;
        sync_in   = sync_v;
        if (gap_mode) begin
            if (gap_en) src_idx++;                         // R9 source advance
            d = pat(src_idx + 5000);
        end else begin
            d = pat(cyc * 3 + 1);
        end
        if (p <= OHL) begin
            if (!gap_mode && !ext_oh_en) d = ~ref_oh(p);   // R3 wrong slot content
            e  = (gap_mode || !ext_oh_en) ? ref_oh(p) : d;
            tg = ovh_tag;
        end else begin
            if (gap_mode) begin
                e = pat(info_cnt + 5000);
                info_cnt++;
            end else begin
                e = d;
            end
            tg = dat_tag;
        end
        ser_in = d;
        oq.push_back('{cyc + 2, e, (p == 1), tg});
        gq.push_back('{cyc + 1, (p > OHL)});
        bpos = (p == FRAME) ? 1 : p + 1;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit gm, input bit eoh, input bit es, input bit r, input bit n);
        rst_n       = 1'b0;
        gap_mode    = gm;
        ext_oh_en   = eoh;
        ext_sync_en = es;
        rai_in      = r;
        nat_in      = n;
        ser_in      = 1'b0;
        sync_in     = 1'b0;
        oq.delete();
        gq.delete();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "nrz_out in reset", nrz_out, 1'b0);
        chk("R11", "fs_out in reset", fs_out, 1'b0);
        chk("R11", "gap_en in reset", gap_en, 1'b0);
        bpos      = 1;
        last_sync = 1'b1;
        src_idx   = 0;
        info_cnt  = 0;
        rst_n     = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        // R2 internal overhead, rai=1 nat=0, R5 data latency
        do_reset(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        ovh_tag = "R2";
        dat_tag = "R5";
        repeat (2 * FRAME + 20) drive_cycle(1'b0);

        // R3 slots ignored, rai=0 nat=1
        do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        ovh_tag = "R3";
        repeat (FRAME + 20) drive_cycle(1'b0);

        // R4 pass-through of external overhead
        do_reset(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        ovh_tag = "R4";
        dat_tag = "R4";
        repeat (FRAME + 20) drive_cycle(1'b0);

        // R6 realign to external sync mid-frame, then an aligned pulse
        do_reset(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        ovh_tag = "R6";
        dat_tag = "R6";
        repeat (300) drive_cycle(1'b0);
        repeat (5) drive_cycle(1'b1);
        repeat (FRAME + 50) drive_cycle(1'b0);
        while (bpos != 1) drive_cycle(1'b0);
        repeat (3) drive_cycle(1'b1);
        repeat (100) drive_cycle(1'b0);

        // R7 sync ignored while free-running
        ext_sync_en = 1'b0;
        ovh_tag = "R7";
        dat_tag = "R7";
        repeat (200) drive_cycle(1'b0);
        repeat (4) drive_cycle(1'b1);
        repeat (FRAME + 50) drive_cycle(1'b0);

        // R9 gapped source order, R10 ext_oh_en ignored in gapped mode
        do_reset(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        ovh_tag = "R10";
        dat_tag = "R9";
        repeat (3 * FRAME) drive_cycle(1'b0);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule